// File: doc/BRIEF.md
# Selective Scan-Chain Stitcher for Chained Core Test Ports

This block puts a row of core test access ports (TAPs) behind one external boundary-scan pin set. It has a small master TAP of its own, the first stage of the chain. Behind the master, the cores are joined in a fixed series order. An enable register holds one bit per core. The tester writes it by shifting the data register that one instruction of the master selects. Any subset of cores may be enabled at the same time, whatever their position in the chain.

An enabled core takes its serial input from the chain data arriving from the master side. A disabled core gets a constant 0 on its serial input. When the tester shifts an instruction, that core therefore fills its instruction register with zeros, which is its idle or bypass opcode. The serial output of a disabled core is skipped: the next enabled core, or the external TDO, sees the data that would have entered the skipped core. The per-core input muxes and the skip path are combinational. Each enabled core therefore adds only its own register length to the scan path.

TCK and TMS go to every core without change. There is only one external pin set, however many cores are present. When the tester keeps the cores it does not need out of the chain, every scan takes fewer TCK cycles.

Top module: `mtap_stitch`

## Requirements
- R1: While `trst_n` is low, the master state machine is held in Test-Logic-Reset, the enable register is all zeros and every `core_tdi` bit is 0.
- R2: `core_tck` follows `tck` and `core_tms` follows `tms` at every instant.
- R3: A core whose enable bit is 0 always sees `core_tdi` = 0, whatever the chain carries.
- R4: An enabled core k gets on `core_tdi[k]` the `core_tdo` of the nearest enabled core with a lower index. If no such core exists, it gets the master's serial output.
- R5: `tdo` carries the `core_tdo` of the highest-index enabled core. When no core is enabled, it carries the master's serial output. A disabled core's `core_tdo` never reaches `tdo`, so each enabled core adds exactly its own register length to the path.
- R6: Instruction code 4'b0101 selects the N-bit enable register as the master's data register. It shifts LSB first: `tdi` enters at the MSB and bit 0 leaves first. The shifted value is applied only at Update-DR, and the enable bits hold their value for the whole shift.
- R7: Capture-IR loads 4'b0001 into the master instruction shifter. That value leaves LSB first during Shift-IR.
- R8: Capture-DR under code 4'b0101 loads the current enable register, so the tester reads the present enables back.
- R9: Every other instruction code, including all-ones, selects a 1-bit bypass register that captures 0. The master then adds exactly one cycle of delay.
- R10: Entering Test-Logic-Reset through TMS clears the enable register and sets the master instruction to all-ones (bypass).
- R11: Several enable bits may be set together in any pattern, and routing follows R3 to R5 for each pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | External test clock |
| trst_n | input | 1 | External test reset, active low, asynchronous |
| tms | input | 1 | External test mode select |
| tdi | input | 1 | External serial data in |
| tdo | output | 1 | External serial data out, end of the stitched path |
| core_tck | output | 1 | Test clock fanned out to every core TAP |
| core_tms | output | 1 | Mode select fanned out to every core TAP |
| core_tdi | output | N | Serial data into each core TAP |
| core_tdo | input | N | Serial data out of each core TAP |

## Verification
If the enable register holds a wrong bit, the fault shows on `core_tdi` as soon as the register has settled. The disabled core's input stops being 0, or an enabled core's input is cut off. The same fault changes the path length seen at `tdo`, so the very next scan returns its data shifted by one position. A wrong master state or instruction shows within one scan: the captured 4'b0001 pattern, the readback of the enables, or the single bypass delay comes out at the wrong bit position on `tdo`. An enable register that changes before Update-DR alters `core_tdi` during the shift itself, while bits are still being shifted.

// File: rtl/mtap_pkg.sv
package mtap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  // Next state of the test port controller for one TCK rising edge.
  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

  // Value loaded into the instruction shifter at Capture-IR.
  function automatic logic [15:0] ir_capture_pattern();
    return 16'h0001;
  endfunction

endpackage

// File: rtl/mtap_fsm.sv
module mtap_fsm
  import mtap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output logic       in_tlr,
  output logic       cap_ir,
  output logic       sh_ir,
  output logic       upd_ir,
  output logic       cap_dr,
  output logic       sh_dr,
  output logic       upd_dr
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= tap_next(state_q, tms);
  end

  assign in_tlr = (state_q == ST_TLR);
  assign cap_ir = (state_q == ST_CAP_IR);
  assign sh_ir  = (state_q == ST_SH_IR);
  assign upd_ir = (state_q == ST_UPD_IR);
  assign cap_dr = (state_q == ST_CAP_DR);
  assign sh_dr  = (state_q == ST_SH_DR);
  assign upd_dr = (state_q == ST_UPD_DR);

endmodule

// File: rtl/mtap_regs.sv
module mtap_regs #(
  parameter int              N      = 4,
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] CFG_OP = 4'h5
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  input  logic            cap_dr,
  input  logic            sh_dr,
  input  logic            upd_dr,
  output logic [N-1:0]    en_q,
  output logic [IR_W-1:0] ir_sr,
  output logic            master_so
);

  localparam logic [IR_W-1:0] IR_CAP = IR_W'(mtap_pkg::ir_capture_pattern());
  localparam logic [IR_W-1:0] IR_BYP = '1;

  logic [IR_W-1:0] ir_q;
  logic [N-1:0]    cfg_sr;
  logic            byp_q;
  logic            cfg_sel;

  assign cfg_sel = (ir_q == CFG_OP);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= '0;
      ir_q   <= IR_BYP;
      cfg_sr <= '0;
      en_q   <= '0;
      byp_q  <= 1'b0;
    end else begin
      if (in_tlr) begin
        ir_q <= IR_BYP;
        en_q <= '0;
      end
      if (cap_ir)     ir_sr <= IR_CAP;
      else if (sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (upd_ir)     ir_q  <= ir_sr;
      if (cfg_sel) begin
        if (cap_dr)     cfg_sr <= en_q;
        else if (sh_dr) cfg_sr <= {tdi, cfg_sr[N-1:1]};
        if (upd_dr)     en_q   <= cfg_sr;
      end else begin
        if (cap_dr)     byp_q <= 1'b0;
        else if (sh_dr) byp_q <= tdi;
      end
    end
  end

  always_comb begin
    if (sh_ir)        master_so = ir_sr[0];
    else if (cfg_sel) master_so = cfg_sr[0];
    else              master_so = byp_q;
  end

endmodule

// File: rtl/mtap_route.sv
module mtap_route #(
  parameter int N = 4
) (
  input  logic [N-1:0] en,
  input  logic         master_so,
  input  logic [N-1:0] core_tdo,
  output logic [N-1:0] core_tdi,
  output logic         chain_out
);

  // Walk the chain from the master side; a disabled core is skipped.
  always_comb begin
    logic feed;
    feed = master_so;
    for (int k = 0; k < N; k++) begin
      core_tdi[k] = en[k] & feed;
      if (en[k]) feed = core_tdo[k];
    end
    chain_out = feed;
  end

endmodule

// File: rtl/mtap_stitch.sv
module mtap_stitch
  import mtap_pkg::*;
#(
  parameter int              N      = 4,
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] CFG_OP = 4'h5
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tms,
  input  logic         tdi,
  output logic         tdo,
  output logic         core_tck,
  output logic         core_tms,
  output logic [N-1:0] core_tdi,
  input  logic [N-1:0] core_tdo
);

  tap_state_e      state_q;
  logic            in_tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
  logic [N-1:0]    en_q;
  logic [IR_W-1:0] ir_sr;
  logic            master_so;

  assign core_tck = tck;
  assign core_tms = tms;

  mtap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q),
    .in_tlr(in_tlr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
  );

  mtap_regs #(.N(N), .IR_W(IR_W), .CFG_OP(CFG_OP)) u_regs (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .in_tlr(in_tlr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
    .en_q(en_q), .ir_sr(ir_sr), .master_so(master_so)
  );

  mtap_route #(.N(N)) u_route (
    .en(en_q), .master_so(master_so), .core_tdo(core_tdo),
    .core_tdi(core_tdi), .chain_out(tdo)
  );

endmodule

// File: rtl/mtap_stitch_chk.sv
module mtap_stitch_chk
  import mtap_pkg::*;
#(
  parameter int N    = 4,
  parameter int IR_W = 4
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tdo,
  input logic            master_so,
  input logic [N-1:0]    core_tdi,
  input logic [N-1:0]    en_q,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_sr
);

  localparam logic [IR_W-1:0] IR_CAP = IR_W'(ir_capture_pattern());

  p_dis_zero_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (core_tdi & ~en_q) == '0);

  p_none_tdo_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (en_q == '0) |-> (tdo == master_so));

  p_en_hold_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q != ST_UPD_DR && state_q != ST_TLR) |=> $stable(en_q));

  p_cap_ir_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_CAP_IR) |=> (ir_sr == IR_CAP));

  p_tlr_clr_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_TLR) |=> (en_q == '0));

endmodule

bind mtap_stitch mtap_stitch_chk #(.N(N), .IR_W(IR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tdo(tdo), .master_so(master_so),
  .core_tdi(core_tdi), .en_q(en_q), .state_q(state_q), .ir_sr(ir_sr)
);

// File: tb/mtap_stitch_tb.sv
`timescale 1ns/1ps
module mtap_stitch_tb;

  localparam int N = 4;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_CFG = 4'b0101;
  localparam logic [IR_W-1:0] OP_BYP = 4'b1111;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, core_tck, core_tms;
  logic [N-1:0] core_tdi, core_tdo, core_q, drv;
  logic model_on = 1'b1;
  logic [N-1:0] cur_en = '0;
  int nchk = 0, nerr = 0;

  always #2.5 tck = ~tck;

  // Bench core model: each core sits in bypass, one flop of delay.
  always @(posedge tck) core_q <= core_tdi;
  assign core_tdo = model_on ? core_q : drv;

  mtap_stitch #(.N(N), .IR_W(IR_W)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .core_tck(core_tck), .core_tms(core_tms),
    .core_tdi(core_tdi), .core_tdo(core_tdo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitclk(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m; tdi = d;
    #1 o = tdo;
  endtask

  task automatic go_idle();
    logic o;
    for (int i = 0; i < 5; i++) bitclk(1'b1, 1'b0, o);
    bitclk(1'b0, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [IR_W-1:0] v, output logic [IR_W-1:0] cap);
    logic o;
    bitclk(1, 0, o); bitclk(1, 0, o); bitclk(0, 0, o); bitclk(0, 0, o);
    for (int i = 0; i < IR_W; i++) begin
      bitclk(i == IR_W-1, v[i], o);
      cap[i] = o;
    end
    bitclk(1, 0, o); bitclk(0, 0, o);
  endtask

  task automatic shift_dr(input int len, input logic [63:0] v, input logic watch,
                          output logic [63:0] cap);
    logic o;
    cap = '0;
    bitclk(1, 0, o); bitclk(0, 0, o); bitclk(0, 0, o);
    for (int i = 0; i < len; i++) begin
      bitclk(i == len-1, v[i], o);
      cap[i] = o;
      // R6: enables must not move while the new value is still shifting
      if (watch) chk("R6 core_tdi during shift", 64'(core_tdi), 64'(0));
    end
    bitclk(1, 0, o); bitclk(0, 0, o);
  endtask

  // Write new enables through the 0101 register, reading old ones back (R8).
  task automatic write_en(input logic [N-1:0] e, input logic watch);
    logic [63:0] cap;
    logic [IR_W-1:0] ic;
    int k;
    k = $countones(cur_en);
    model_on = 1'b1;
    shift_ir(OP_CFG, ic);
    shift_dr(N + k, 64'(e) << k, watch, cap);
    chk("R8 enable readback", 64'(cap[k +: N]), 64'(cur_en));
    cur_en = e;
  endtask

  task automatic t_reset();
    chk("R1 core_tdi in trst", 64'(core_tdi), 64'(0));
    tms = 1'b0; #1;
    chk("R2 core_tms low", 64'(core_tms), 64'(0));
    tms = 1'b1; #1;
    chk("R2 core_tms high", 64'(core_tms), 64'(1));
    @(negedge tck); #0.5;
    chk("R2 core_tck low", 64'(core_tck), 64'(0));
    @(posedge tck); #0.5;
    chk("R2 core_tck high", 64'(core_tck), 64'(1));
    @(negedge tck); trst_n = 1'b1;
    go_idle();
  endtask

  task automatic t_ir_capture();
    logic [IR_W-1:0] cap;
    shift_ir(OP_CFG, cap);
    chk("R7 IR capture 0001", 64'(cap), 64'(4'b0001));
  endtask

  task automatic t_route(input logic [N-1:0] e);
    logic [N-1:0] d, exp_tdi;
    logic f;
    write_en(e, cur_en == '0);
    model_on = 1'b1;
    for (int p = 0; p < 3; p++) begin
      d = (p == 0) ? 4'b0101 : (p == 1) ? 4'b1010 : 4'b0011;
      @(negedge tck);
      model_on = 1'b0; drv = d;
      #1;
      f = e[0]; // master output = bit 0 of last shifted enable word
      for (int k = 0; k < N; k++) begin
        exp_tdi[k] = e[k] ? f : 1'b0;
        if (e[k]) f = d[k];
      end
      // R3 R4 R11: per-core inputs; R5: external tdo
      chk("R4 R3 R11 core_tdi routing", 64'(core_tdi), 64'(exp_tdi));
      chk("R5 tdo from last enabled core", 64'(tdo), 64'(f));
    end
    model_on = 1'b1;
  endtask

  task automatic t_bypass(input logic [IR_W-1:0] op);
    logic [IR_W-1:0] ic;
    logic [63:0] cap;
    logic [7:0] v;
    v = 8'b1011_0110;
    write_en('0, 1'b0);
    shift_ir(op, ic);
    shift_dr(8, 64'(v), 1'b0, cap);
    chk("R9 bypass one-cycle delay", 64'(cap[7:0]), 64'({v[6:0], 1'b0}));
  endtask

  task automatic t_tlr();
    logic [IR_W-1:0] ic;
    logic [63:0] cap;
    write_en(4'b1011, 1'b0);
    go_idle();
    cur_en = '0;
    @(negedge tck); model_on = 1'b0; drv = 4'b1111; #1;
    chk("R10 enables cleared by TLR", 64'(core_tdi), 64'(0));
    model_on = 1'b1;
    shift_dr(4, 64'(4'b1101), 1'b0, cap);
    chk("R10 IR reset to bypass", 64'(cap[3:0]), 64'(4'b1010));
    shift_ir(OP_CFG, ic);
    chk("R10 R7 IR capture after TLR", 64'(ic), 64'(4'b0001));
  endtask

  task automatic t_trst();
    write_en(4'b0110, 1'b0);
    @(negedge tck); trst_n = 1'b0; model_on = 1'b0; drv = 4'b1111; #1;
    chk("R1 trst clears routing", 64'(core_tdi), 64'(0));
    @(negedge tck); trst_n = 1'b1; model_on = 1'b1;
    cur_en = '0;
    go_idle();
    write_en(4'b0001, 1'b1);
  endtask

  initial begin
    drv = '0;
    #1;
    t_reset();
    t_ir_capture();
    t_route(4'b1010);
    t_route(4'b0110);
    t_route(4'b1111);
    t_route(4'b1001);
    t_route(4'b0000);
    t_bypass(OP_BYP);
    t_bypass(4'b0011);
    t_tlr();
    t_trst();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule